// File: doc/BRIEF.md
# Per-Pin Asymmetric Input Noise Canceler

This block conditions the eight input pins of one general-purpose port before software reads them. Each pin passes through a two-flop synchronizer. It then either goes straight to a readback register or through its own filter. Software picks a level for each filtered pin. That level is accepted only after it has been seen on three sampling strobes in a row. The opposite level is accepted on the first strobe that sees it. A glitch toward the chosen level is therefore rejected, while a move away from it shows up at once.

All eight filters share one free-running divider that produces a sampling strobe every 2, 4, 8 or 16 clocks. Configuration and readback go through a small synchronous register bus: a 2-bit address, a write enable, write data and combinational read data.

Each pin filter is a four-state machine:

- PASS: filtering is off, and the readback bit copies the synchronized pin on every clock.
- IDLE: filtering is on and no count is running.
- RUN: the chosen level has been seen on one or more strobes, but not yet three.
- LOCK: the chosen level has been accepted.

The transitions are:

- Any state goes to IDLE when software changes that pin's enable or level bit. The readback bit is held and the count is cleared.
- IDLE, RUN or LOCK goes to PASS when the enable is 0.
- PASS goes to IDLE when the enable is 1.
- IDLE, RUN or LOCK goes to IDLE when a strobe sees the other level. The readback bit takes that level.
- IDLE or RUN goes to RUN when a strobe sees the chosen level and the count stays below three.
- IDLE or RUN goes to LOCK on the third such strobe. The readback bit takes the chosen level.
- LOCK stays in LOCK while strobes keep seeing the chosen level.

Top module: `nc_port_filter`

## Requirements
- R1: After reset, the enable register, the level register, the sampling-select register and the readback register all read 0.
- R2: With a pin's enable bit at 0, its readback bit equals the pin value as it stood 3 clocks earlier (two synchronizer flops plus the readback flop).
- R3: With a pin's enable bit at 1, the pin's selected level (level bit 1 means high, 0 means low) enters the readback bit only after three consecutive sampling strobes have all seen that level.
- R4: With a pin's enable bit at 1, the level opposite to the selected one enters the readback bit on the first sampling strobe that sees it.
- R5: The sampling-select code s (values 0 to 3) gives one strobe every 2^(s+1) clocks, from a divider that starts at reset. The readback bit of an enabled pin changes only on a strobe, or when its enable is 0.
- R6: A write that changes a pin's enable bit or level bit clears that pin's count of consecutive strobes. It also holds the pin's readback bit in that cycle, even when a strobe falls in the same cycle.
- R7: The address map is: 0 = enable, 1 = level, 2 = sampling select in bits [1:0] with the upper bits reading 0, and 3 = readback. Writes to address 3 are ignored.
- R8: Each pin is filtered on its own. Enabling one pin leaves the bypass behaviour of the other pins unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| pin_in | input | 8 | Raw asynchronous port pins |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |

## Verification
The cycles that need care are those where a configuration write and a sampling strobe fall on the same clock. Clearing a pin's count must then win over both counting and accepting a level. The bench provokes this by holding a pin at its selected level and toggling its enable off and on in back-to-back writes, every 26 clocks, with a 16-clock strobe period. The write lands on a different strobe phase each time, so some writes meet a strobe. The readback must never reach the selected level during this, because no write interval covers three strobes. Once the writes stop, the readback must reach the selected level.

// File: rtl/nc_pkg.sv
package nc_pkg;

    typedef enum logic [1:0] {
        NC_A_EN  = 2'd0,
        NC_A_LVL = 2'd1,
        NC_A_SEL = 2'd2,
        NC_A_RB  = 2'd3
    } nc_addr_e;

    typedef enum logic [1:0] {
        FS_PASS,
        FS_IDLE,
        FS_RUN,
        FS_LOCK
    } nc_fstate_e;

endpackage

// File: rtl/nc_sync.sv
module nc_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q_o    <= '0;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/nc_strobe_div.sv
module nc_strobe_div #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    output logic             stb_o
);
    localparam int DIV_W = 1 << SEL_W;

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W:0]   span;

    // strobe when the low (sel+1) bits of the counter are all ones
    always_comb begin
        span  = ((DIV_W + 1)'(2) << sel_i) - (DIV_W + 1)'(1);
        stb_o = ((cnt_q & span[DIV_W-1:0]) == span[DIV_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + DIV_W'(1);
    end
endmodule

// File: rtl/nc_bit_filter.sv
module nc_bit_filter
    import nc_pkg::*;
#(
    parameter int STABLE_N = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    input  logic en_i,
    input  logic lvl_i,
    input  logic stb_i,
    input  logic clr_i,
    output logic rb_o
);
    localparam int CW = $clog2(STABLE_N + 1);

    nc_fstate_e     state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic           rb_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FS_PASS;
        else        state_q <= state_d;
    end

    // output and count registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rb_o  <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            rb_o  <= rb_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        rb_d    = rb_o;
        if (clr_i) begin
            state_d = FS_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                FS_PASS: begin
                    rb_d = sync_i;
                    if (en_i) state_d = FS_IDLE;
                end
                FS_IDLE, FS_RUN, FS_LOCK: begin
                    if (!en_i) begin
                        rb_d    = sync_i;
                        cnt_d   = '0;
                        state_d = FS_PASS;
                    end else if (stb_i) begin
                        if (sync_i != lvl_i) begin
                            rb_d    = sync_i;
                            cnt_d   = '0;
                            state_d = FS_IDLE;
                        end else if (state_q == FS_LOCK) begin
                            state_d = FS_LOCK;
                        end else if (cnt_q == CW'(STABLE_N - 1)) begin
                            rb_d    = lvl_i;
                            cnt_d   = '0;
                            state_d = FS_LOCK;
                        end else begin
                            cnt_d   = cnt_q + CW'(1);
                            state_d = FS_RUN;
                        end
                    end
                end
                default: state_d = FS_PASS;
            endcase
        end
    end
endmodule

// File: rtl/nc_port_filter.sv
module nc_port_filter
    import nc_pkg::*;
#(
    parameter int PINS     = 8,
    parameter int SEL_W    = 2,
    parameter int STABLE_N = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_in,
    input  logic [1:0]      bus_addr,
    input  logic            bus_we,
    input  logic [PINS-1:0] bus_wdata,
    output logic [PINS-1:0] bus_rdata
);
    logic [PINS-1:0]  en_q, lvl_q, sync, rb, clr;
    logic [SEL_W-1:0] sel_q;
    logic             stb;
    nc_addr_e         addr;

    assign addr = nc_addr_e'(bus_addr);

    // a write that flips a pin's enable or level bit restarts that pin
    always_comb begin
        clr = '0;
        if (bus_we && addr == NC_A_EN)  clr = bus_wdata ^ en_q;
        if (bus_we && addr == NC_A_LVL) clr = bus_wdata ^ lvl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            lvl_q <= '0;
            sel_q <= '0;
        end else if (bus_we) begin
            unique case (addr)
                NC_A_EN:  en_q  <= bus_wdata;
                NC_A_LVL: lvl_q <= bus_wdata;
                NC_A_SEL: sel_q <= bus_wdata[SEL_W-1:0];
                NC_A_RB:  ;
                default:  ;
            endcase
        end
    end

    always_comb begin
        unique case (addr)
            NC_A_EN:  bus_rdata = en_q;
            NC_A_LVL: bus_rdata = lvl_q;
            NC_A_SEL: bus_rdata = PINS'(sel_q);
            NC_A_RB:  bus_rdata = rb;
            default:  bus_rdata = '0;
        endcase
    end

    nc_sync #(.W(PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(pin_in), .q_o(sync)
    );

    nc_strobe_div #(.SEL_W(SEL_W)) u_div (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_q), .stb_o(stb)
    );

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        nc_bit_filter #(.STABLE_N(STABLE_N)) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .sync_i(sync[i]),
            .en_i  (en_q[i]),
            .lvl_i (lvl_q[i]),
            .stb_i (stb),
            .clr_i (clr[i]),
            .rb_o  (rb[i])
        );
    end
endmodule

// File: rtl/nc_port_filter_chk.sv
module nc_port_filter_chk #(
    parameter int PINS = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            stb,
    input logic [PINS-1:0] sync,
    input logic [PINS-1:0] en_q,
    input logic [PINS-1:0] lvl_q,
    input logic [PINS-1:0] clr,
    input logic [PINS-1:0] rb
);
    // R2: bypassed pins copy the synchronized value one clock later
    assert_bypass_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((rb ^ $past(sync)) & $past(~en_q & ~clr)) == '0);

    // R4: opposite level taken on the strobe that sees it
    assert_opposite_fast_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> ((rb ^ $past(sync)) & $past(en_q & ~clr & (sync ^ lvl_q))) == '0);

    // R5: strobes never fall on adjacent clocks
    assert_strobe_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> !stb);

    // R5: an enabled pin's readback moves only on a strobe
    assert_change_on_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> ((rb ^ $past(rb)) & $past(en_q & ~clr)) == '0);

    // R6: a configuration change holds the readback bit
    assert_hold_on_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr != '0) |=> ((rb ^ $past(rb)) & $past(clr)) == '0);
endmodule

bind nc_port_filter nc_port_filter_chk #(.PINS(PINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .stb(stb), .sync(sync),
    .en_q(en_q), .lvl_q(lvl_q), .clr(clr), .rb(rb)
);

// File: tb/sim_nc_port_filter.sv
`timescale 1ns/1ps
module sim_nc_port_filter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_in = '0;
    logic [1:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    nc_port_filter u0 (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // bypass vectors: pin pattern, expected readback 3 clocks later
    localparam logic [15:0] BYP_VEC [6] = '{
        16'h00_00, 16'hA5_A5, 16'h5A_5A, 16'hFF_FF, 16'h3C_3C, 16'h00_00
    };
    localparam logic [1:0] SEL_VEC [4] = '{2'd0, 2'd1, 2'd2, 2'd3};

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic wr_pair(input logic [1:0] a, input logic [7:0] d0, input logic [7:0] d1);
        @(negedge clk); bus_addr = a; bus_we = 1'b1; bus_wdata = d0;
        @(negedge clk); bus_wdata = d1;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic set_pins(input logic [7:0] v);
        @(negedge clk); pin_in = v;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        edges(3);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset values
        rd(2'd0, d); check("R1 enable reset", d, 8'h00);
        rd(2'd1, d); check("R1 level reset", d, 8'h00);
        rd(2'd2, d); check("R1 select reset", d, 8'h00);
        rd(2'd3, d); check("R1 readback reset", d, 8'h00);

        // R2: bypass table
        for (int i = 0; i < 6; i++) begin
            set_pins(BYP_VEC[i][15:8]);
            edges(2);
            rd(2'd3, d); check("R2 bypass not before 3 clocks", d, (i == 0) ? 8'h00 : BYP_VEC[i-1][7:0]);
            edges(0);
            @(posedge clk);
            rd(2'd3, d); check("R2 bypass after 3 clocks", d, BYP_VEC[i][7:0]);
        end

        // R7: register map
        wr(2'd0, 8'h5A); rd(2'd0, d); check("R7 enable rw", d, 8'h5A);
        wr(2'd1, 8'hC3); rd(2'd1, d); check("R7 level rw", d, 8'hC3);
        wr(2'd2, 8'hFF); rd(2'd2, d); check("R7 select upper bits zero", d, 8'h03);
        wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
        edges(4);

        // R3 level high, bit 0 filtered, others bypassed
        wr(2'd1, 8'h01); wr(2'd0, 8'h01);
        set_pins(8'h01);
        edges(5); rd(2'd3, d); check("R3 high not yet accepted", d & 8'h01, 8'h00);
        edges(6); rd(2'd3, d); check("R3 high accepted after 3 strobes", d, 8'h01);

        // R4 opposite level fast, R8 neighbours bypass
        set_pins(8'hF0);
        edges(4); rd(2'd3, d); check("R4 R8 low taken on first strobe", d, 8'hF0);
        set_pins(8'h00); edges(4);

        // R5: each sampling period
        for (int k = 0; k < 4; k++) begin
            int p;
            p = 2 << SEL_VEC[k];
            wr(2'd2, 8'(SEL_VEC[k]));
            set_pins(8'h00); edges(40);
            set_pins(8'h01); edges(2 * p);
            set_pins(8'h00); edges(2);
            rd(2'd3, d); check("R5 two strobes rejected", d & 8'h01, 8'h00);
            set_pins(8'h01); edges(3 * p + 4);
            rd(2'd3, d); check("R5 three strobes accepted", d & 8'h01, 8'h01);
        end

        // R6: clear by back-to-back enable toggles, 16-clock strobe
        set_pins(8'h00); edges(40);
        rd(2'd3, d); check("R6 start low", d & 8'h01, 8'h00);
        set_pins(8'h01);
        for (int k = 0; k < 6; k++) begin
            edges(23);
            wr_pair(2'd0, 8'h00, 8'h01);
            rd(2'd3, d); check("R6 count cleared, readback held", d & 8'h01, 8'h00);
        end
        edges(60);
        rd(2'd3, d); check("R6 accepted once writes stop", d & 8'h01, 8'h01);

        // R3 and R4 with level low
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h00);
        set_pins(8'h00);
        edges(5); rd(2'd3, d); check("R3 low not yet accepted", d & 8'h01, 8'h01);
        edges(6); rd(2'd3, d); check("R3 low accepted", d & 8'h01, 8'h00);
        set_pins(8'h01);
        edges(4); rd(2'd3, d); check("R4 high taken fast with low level", d & 8'h01, 8'h01);

        // R7: readback is read-only
        wr(2'd3, 8'hFE);
        rd(2'd3, d); check("R7 readback write ignored", d, 8'h01);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule